// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Memory Device Controller

This block is the control logic that sits behind the pins of a byte-wide parallel nonvolatile memory. It runs on a fast system clock. It watches three asynchronous active-low strobes: chip select (`ce_n`), write strobe (`we_n`) and output enable (`oe_n`). From these it decodes read and write accesses to a register array of bytes. Every strobe passes through a flop synchronizer. The address and data buses pass through a delay line of the same depth, so a bus value always lines up with the strobe state that was seen beside it.

During a write, chip select and write strobe together form one combined strobe, which is active while both are low. The address is taken when the combined strobe becomes active, which is the moment the later of the two strobes falls. The data is taken when the combined strobe becomes inactive, which is the moment the earlier of the two strobes rises. After that a self-timed programming interval of a set number of clocks begins, and the `busy` output is high for all of it. The array is updated only when the interval ends. For a read, the block returns the stored byte on `dq_out` and raises `dq_oe`. The pad logic outside the block uses `dq_oe` to enable the tri-state driver.

The full-size device has 8K bytes and a 13-bit address. `ADDR_W` sets the array size. The default is kept at 1K bytes to keep elaboration small.

Top module: `eeprom_devctl`

## Requirements
- R1: In the first cycle after synchronous reset, `busy` is 0 and `dq_oe` is 0, and every array byte reads back as 8'hFF.
- R2: A write access opens only if the combined strobe (`ce_n`=0 and `we_n`=0) becomes active while `oe_n`=1. If `oe_n` goes to 0 before the combined strobe releases, the access is dropped and the array is left unchanged.
- R3: The write address is the value on `addr` at the moment the later of `ce_n`/`we_n` falls. This holds whether the write is controlled by the write strobe or by chip select. Address changes made later in the access have no effect.
- R4: The write data is the value on `dq_in` at the moment the earlier of `ce_n`/`we_n` rises. Data changes made after that moment have no effect.
- R5: `busy` rises in the cycle that the release of the combined strobe is registered. It then stays high for exactly `WRITE_CYCLES` consecutive cycles.
- R6: A write access that opens while `busy` is high is ignored. It changes neither the array nor the length of the busy interval.
- R7: `dq_oe` is 1 when the synchronized strobes show `ce_n`=0, `oe_n`=0 and `we_n`=1. In that case `dq_out` is the array byte at `addr`.
- R8: `dq_oe` is 0 whenever the synchronized `ce_n` or `oe_n` is 1.
- R9: While `busy` is high, a read of the byte being programmed returns its old contents. From the cycle after `busy` falls, it returns the new byte.
- R10: Any change at the strobe, address or data pins shows at `dq_oe`/`dq_out` three clock edges later: `SYNC_STAGES` synchronizer edges plus one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Asynchronous chip select, active low |
| we_n | input | 1 | Asynchronous write strobe, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_in | input | DATA_W | Data bus as seen from the pad (write data) |
| dq_out | output | DATA_W | Read data toward the pad driver |
| dq_oe | output | 1 | Enable for the pad tri-state driver |
| busy | output | 1 | Self-timed programming interval in progress |

## Verification
The bench runs write accesses of both kinds. In a chip-select-controlled write, the write strobe falls first and chip select falls last. In a write-strobe-controlled write, the order is reversed. Between the edges the bench moves the address and data around. A design that latched on the first falling strobe would program the wrong byte. A design that latched on the last rising strobe would store the late data.

The bench also:
- reads the target byte in the middle of the busy interval. A controller that writes the array at commit time would return the new value too early.
- starts a write during `busy`. A controller without the guard would program a second byte or stretch the interval.
- drops `oe_n` in the middle of an access. This catches designs that commit accesses they should have aborted.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    // Active-low strobe bundle as it travels through the synchronizer
    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    localparam int STROBE_W = $bits(strobe_t);
    localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

    typedef enum logic [0:0] {
        WS_IDLE  = 1'b0,
        WS_ARMED = 1'b1
    } wr_state_t;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    // Combined write strobe: active while chip select and write strobe are both low
    function automatic logic combined_low(input strobe_t s);
        return !s.ce_n && !s.we_n;
    endfunction

    // Output drive condition for a read
    function automatic logic read_drive(input strobe_t s);
        return !s.ce_n && !s.oe_n && s.we_n;
    endfunction

endpackage

// File: rtl/eeprom_sync.sv
module eeprom_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/eeprom_wr_ctl.sv
module eeprom_wr_ctl
    import eeprom_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           stb,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic              busy,
    output logic              commit,
    output logic              armed,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [DATA_W-1:0] pend_data
);
    wr_state_t         state;
    logic              strb_prev;
    logic              strb_now;
    logic              strb_rise;
    logic              strb_fall;
    logic [ADDR_W-1:0] lat_addr;

    assign strb_now  = combined_low(stb);
    assign strb_rise = strb_now && !strb_prev;
    assign strb_fall = !strb_now && strb_prev;
    assign armed     = (state == WS_ARMED);
    // Commit when the first of the two strobes releases, provided the cycle was not aborted
    assign commit    = armed && stb.oe_n && strb_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= WS_IDLE;
            strb_prev <= 1'b0;
            lat_addr  <= '0;
            pend_addr <= '0;
            pend_data <= '0;
        end else begin
            strb_prev <= strb_now;
            unique case (state)
                WS_IDLE: begin
                    // Later-falling strobe opens the access; address taken here
                    if (strb_rise && stb.oe_n && !busy) begin
                        lat_addr <= addr_s;
                        state    <= WS_ARMED;
                    end
                end
                WS_ARMED: begin
                    if (!stb.oe_n) begin
                        state <= WS_IDLE;
                    end else if (strb_fall) begin
                        pend_addr <= lat_addr;
                        pend_data <= data_s;
                        state     <= WS_IDLE;
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/eeprom_busy_timer.sv
module eeprom_busy_timer #(
    parameter int WRITE_CYCLES = 500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WRITE_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign done = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= LOAD;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array
    import eeprom_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  strobe_t           stb,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] ERASED = {(DATA_W + 7) / 8{ERASED_BYTE}};

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_oe   <= 1'b0;
            rd_data <= ERASED;
        end else begin
            rd_oe   <= read_drive(stb);
            rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/eeprom_devctl.sv
module eeprom_devctl
    import eeprom_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int DATA_W       = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int WRITE_CYCLES = 500_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              busy
);
    localparam int BUS_W = ADDR_W + DATA_W;

    strobe_t           stb_raw;
    logic [STROBE_W-1:0] stb_sync_vec;
    strobe_t           stb_s;
    logic [BUS_W-1:0]  bus_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic              commit;
    logic              armed;
    logic              done;
    logic [ADDR_W-1:0] pend_addr;
    logic [DATA_W-1:0] pend_data;

    assign stb_raw = '{ce_n: ce_n, we_n: we_n, oe_n: oe_n};

    eeprom_sync #(.W(STROBE_W), .STAGES(SYNC_STAGES), .RST_VAL(STROBE_IDLE)) u_stb_sync (
        .clk (clk), .rst (rst), .din (stb_raw), .dout (stb_sync_vec)
    );
    assign stb_s = strobe_t'(stb_sync_vec);

    // Bus delay line matched to the strobe synchronizer depth
    eeprom_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_dly (
        .clk (clk), .rst (rst), .din ({addr, dq_in}), .dout (bus_s)
    );
    assign addr_s = bus_s[BUS_W-1:DATA_W];
    assign data_s = bus_s[DATA_W-1:0];

    eeprom_wr_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk (clk), .rst (rst), .stb (stb_s), .addr_s (addr_s), .data_s (data_s),
        .busy (busy), .commit (commit), .armed (armed),
        .pend_addr (pend_addr), .pend_data (pend_data)
    );

    eeprom_busy_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_tmr (
        .clk (clk), .rst (rst), .start (commit), .busy (busy), .done (done)
    );

    eeprom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk (clk), .rst (rst), .wr_en (done), .wr_addr (pend_addr), .wr_data (pend_data),
        .stb (stb_s), .rd_addr (addr_s), .rd_data (dq_out), .rd_oe (dq_oe)
    );
endmodule

// File: rtl/eeprom_devctl_chk.sv
module eeprom_devctl_chk #(
    parameter int ADDR_W       = 10,
    parameter int DATA_W       = 8,
    parameter int WRITE_CYCLES = 500_000
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              dq_oe,
    input logic              busy,
    input logic              armed,
    input logic [ADDR_W-1:0] pend_addr,
    input logic [DATA_W-1:0] pend_data
);
    localparam int RUN_W = $clog2(WRITE_CYCLES + 2);
    logic [RUN_W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst)       run <= '0;
        else if (busy) run <= run + 1'b1;
        else           run <= '0;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) $fell(rst) |-> (!busy && !dq_oe));

    // R2
    busy_needs_access_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(armed));

    // R5
    busy_length_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && run >= RUN_W'(WRITE_CYCLES)));

    // R6
    pending_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(pend_addr) && $stable(pend_data)));

    // R8
    drive_cond_chk: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (!$past(ce_n, 3) && !$past(oe_n, 3) && $past(we_n, 3)));
endmodule

bind eeprom_devctl eeprom_devctl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
    .clk (clk), .rst (rst), .ce_n (ce_n), .we_n (we_n), .oe_n (oe_n),
    .dq_oe (dq_oe), .busy (busy), .armed (armed),
    .pend_addr (pend_addr), .pend_data (pend_data)
);

// File: tb/tb_eeprom_devctl.sv
module tb_eeprom_devctl;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam int WC = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe, busy;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    eeprom_devctl #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2), .WRITE_CYCLES(WC)) dut (
        .clk (clk), .rst (rst), .ce_n (ce_n), .we_n (we_n), .oe_n (oe_n),
        .addr (addr), .dq_in (dq_in), .dq_out (dq_out), .dq_oe (dq_oe), .busy (busy)
    );

    // ---------------- behavioural reference ----------------
    typedef struct { bit ce, we, oe; int a, d; } pins_t;
    pins_t q[$];
    logic [DW-1:0] mm [int];
    bit m_prev, m_cyc, m_busy, m_oe;
    int m_lat, m_pa, m_pd, m_cnt;
    logic [DW-1:0] m_dout;

    function automatic logic [DW-1:0] mrd(int a);
        return mm.exists(a) ? mm[a] : 8'hFF;
    endfunction

    always @(posedge clk) begin
        pins_t now, p2;
        bit strb, b_old;
        now = '{ce: ce_n, we: we_n, oe: oe_n, a: int'(addr), d: int'(dq_in)};
        if (rst) begin
            q.delete();
            q.push_back('{ce: 1, we: 1, oe: 1, a: 0, d: 0});
            q.push_back('{ce: 1, we: 1, oe: 1, a: 0, d: 0});
            mm.delete();
            m_prev = 0; m_cyc = 0; m_busy = 0; m_oe = 0; m_cnt = 0;
            m_dout = 8'hFF; m_lat = 0; m_pa = 0; m_pd = 0;
        end else begin
            p2 = q[0];
            m_oe = !p2.ce && !p2.oe && p2.we;
            m_dout = mrd(p2.a);
            b_old = m_busy;
            if (m_busy) begin
                if (m_cnt == 0) begin mm[m_pa] = DW'(m_pd); m_busy = 0; end
                else m_cnt--;
            end
            strb = !p2.ce && !p2.we;
            if (m_cyc && !p2.oe) m_cyc = 0;
            else if (m_cyc && !strb && m_prev) begin
                m_busy = 1; m_cnt = WC - 1; m_pa = m_lat; m_pd = p2.d; m_cyc = 0;
            end else if (!m_cyc && strb && !m_prev && p2.oe && !b_old) begin
                m_cyc = 1; m_lat = p2.a;
            end
            m_prev = strb;
            void'(q.pop_front());
            q.push_back(now);
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            chk("R5", "busy vs model", busy, m_busy);
            chk("R8", "dq_oe vs model", dq_oe, m_oe);
            chk("R10", "dq_out vs model", dq_out, m_dout);
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_pins();
        ce_n = 1; we_n = 1; oe_n = 1;
    endtask

    task automatic read_byte(int a, output logic [DW-1:0] v, output logic oe);
        ce_n = 0; we_n = 1; oe_n = 0; addr = AW'(a);
        tick(4);
        v = dq_out; oe = dq_oe;
        idle_pins();
        tick(2);
    endtask

    // Write-strobe controlled: chip select low first, write strobe falls last and rises first
    task automatic write_we(int a, int d);
        ce_n = 0; oe_n = 1; addr = AW'(a + 1);
        tick(1);
        we_n = 0; addr = AW'(a); dq_in = DW'(d ^ 8'h5A);
        tick(2);
        addr = AW'(a + 3); dq_in = DW'(d);
        tick(2);
        we_n = 1;
        tick(1);
        dq_in = DW'(d ^ 8'hC3); ce_n = 1;
        tick(4);
    endtask

    // Chip-select controlled: write strobe low first, chip select falls last and rises first
    task automatic write_ce(int a, int d);
        we_n = 0; oe_n = 1; addr = AW'(a + 2);
        tick(1);
        ce_n = 0; addr = AW'(a); dq_in = DW'(~d);
        tick(2);
        addr = AW'(a + 5); dq_in = DW'(d);
        tick(2);
        ce_n = 1;
        tick(1);
        dq_in = DW'(d ^ 8'h0F); we_n = 1;
        tick(4);
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 1000) begin tick(1); guard++; end
        tick(2);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [DW-1:0] v;
        logic o;
        tick(3);
        rst = 0;
        tick(1);
        // R1 reset state
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "dq_oe after reset", dq_oe, 0);
        read_byte(0, v, o);   chk("R1", "erased byte 0", v, 8'hFF);
        read_byte(1023, v, o); chk("R1", "erased byte top", v, 8'hFF);
        chk("R7", "drive during read", o, 1);

        // R3/R4 write-strobe controlled
        write_we(16, 8'hA5);
        chk("R5", "busy after commit", busy, 1);
        read_byte(16, v, o);
        chk("R9", "old contents during busy", v, 8'hFF);
        wait_idle();
        read_byte(16, v, o);  chk("R4", "data at first rise (WE)", v, 8'hA5);
        read_byte(17, v, o);  chk("R3", "early address untouched", v, 8'hFF);
        read_byte(19, v, o);  chk("R3", "late address untouched", v, 8'hFF);

        // R3/R4 chip-select controlled
        write_ce(40, 8'h3C);
        wait_idle();
        read_byte(40, v, o);  chk("R3", "address at last fall (CE)", v, 8'h3C);
        read_byte(45, v, o);  chk("R4", "late address/data ignored", v, 8'hFF);

        // R6 write during busy is ignored
        write_we(100, 8'h11);
        write_ce(200, 8'h22);
        wait_idle();
        read_byte(100, v, o); chk("R9", "new contents after busy", v, 8'h11);
        read_byte(200, v, o); chk("R6", "write during busy ignored", v, 8'hFF);

        // R2 output enable low aborts
        ce_n = 0; oe_n = 1; addr = 10'd300; dq_in = 8'h77;
        tick(1); we_n = 0; tick(4); oe_n = 0; tick(4); we_n = 1; tick(1);
        idle_pins(); tick(4);
        chk("R2", "aborted access no busy", busy, 0);
        read_byte(300, v, o); chk("R2", "aborted access no write", v, 8'hFF);

        // R2 strobe with OE already low never opens
        oe_n = 0; ce_n = 0; we_n = 0; addr = 10'd301; dq_in = 8'h12;
        tick(5); idle_pins(); tick(4);
        chk("R2", "OE low no busy", busy, 0);

        // R8 high impedance when CE or OE high
        ce_n = 1; oe_n = 0; we_n = 1; addr = 10'd16; tick(4);
        chk("R8", "CE high no drive", dq_oe, 0);
        ce_n = 0; oe_n = 1; tick(4);
        chk("R8", "OE high no drive", dq_oe, 0);
        oe_n = 0; tick(4);
        chk("R7", "read data", dq_out, 8'hA5);
        // R10 latency: drive drops exactly three edges after OE rises
        oe_n = 1; tick(2);
        chk("R10", "drive still on at edge 2", dq_oe, 1);
        tick(1);
        chk("R10", "drive off at edge 3", dq_oe, 0);
        idle_pins(); tick(4);

        // R1 reset restores erased array
        rst = 1; tick(2); rst = 0; tick(1);
        read_byte(16, v, o); chk("R1", "reset erases array", v, 8'hFF);
        finish_run();
    end
endmodule